// File: doc/BRIEF.md
# Misaligned Load Bus Adapter

This block connects a load requester to a memory port that is eight bytes wide and only understands word addresses. A request carries a byte address and a size of 1, 2, 4 or 8 bytes. The adapter turns the byte address into a word index, fetches the word that holds the first byte and, when the requested bytes run past the end of that word, also fetches the following word. It then shifts and masks the fetched bytes into a little-endian, zero-extended 64-bit result and presents it with a one-cycle valid strobe.

A mode input chooses how misalignment is handled. In split mode every access is served, with a second read only when the access spills into the next word. In fault mode any access whose address is not a multiple of its size produces a one-cycle fault strobe and no memory traffic. The adapter serves one request at a time and holds its request ready low from acceptance until the response has been given.

Top module: `mla_adapter`

## Requirements
- R1: The first memory read of an accepted load uses word index `req_addr >> 3`; the three low byte-address bits never reach `mem_addr`.
- R2: A load whose bytes all lie in one word (`req_addr[2:0] + size_bytes <= 8`) performs exactly one memory read, and result byte i (bits 8i+7:8i) is byte `req_addr[2:0] + i` of that word.
- R3: In split mode, a load with `req_addr[2:0] + size_bytes > 8` performs exactly two memory reads, the second at word index `(req_addr >> 3) + 1`.
- R4: For a two-read load, result byte i is byte `req_addr + i` of memory: the upper bytes of the first word followed by the lower bytes of the second.
- R5: Result bytes at positions `size_bytes` and above are zero. Size code on `req_size`: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.
- R6: With `split_en = 0`, a load whose address is not a multiple of its size performs no memory read and raises `rsp_fault` for exactly one cycle, with `rsp_valid` low.
- R7: With `split_en = 0`, a naturally aligned load completes normally; with `split_en = 1`, a misaligned load that stays within one word uses one read.
- R8: `req_ready` is high only when idle; it drops in the cycle after acceptance and stays low through the response cycle.
- R9: `mem_req_valid` and `mem_addr` stay unchanged until `mem_req_ready` is seen; read data may return any number of cycles (at least one) after the handshake.
- R10: After reset the adapter is idle: `req_ready` high, `rsp_valid`, `rsp_fault` and `mem_req_valid` low.
- R11: `rsp_valid` is high for exactly one cycle per completed load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_en | input | 1 | 1: split misaligned loads; 0: fault them |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Adapter idle and accepting |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | 2 | Size code (0:1, 1:2, 2:4, 3:8 bytes) |
| rsp_valid | output | 1 | Result valid, one cycle |
| rsp_data | output | 64 | Zero-extended little-endian result |
| rsp_fault | output | 1 | Misalignment fault, one cycle |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | ADDR_W-3 | Word index of the read |
| mem_rdata_valid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data word |

## Verification
Every byte offset within three consecutive words is tried with all four sizes in both modes, which separates the one-read, two-read and fault outcomes exactly at the word boundary and at each natural-alignment boundary. Memory holds a per-address byte pattern, so a wrong shift, a swapped word order or an unmasked high byte shows up as a different value. A second sweep at a high address runs with a three-cycle read latency and a memory that accepts only every third cycle, which tells apart an adapter that waits for the handshake and data from one that assumes fixed timing.

// File: rtl/mla_pkg.sv
`timescale 1ns/1ps
package mla_pkg;
    localparam int WORD_BYTES = 8;
    localparam int DATA_W     = 8 * WORD_BYTES;
    localparam int OFF_W      = $clog2(WORD_BYTES);
    localparam int NB_W       = OFF_W + 1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ_FIRST,
        ST_READ_SECOND,
        ST_RESPOND
    } state_e;

    typedef struct packed {
        logic [OFF_W-1:0] offset;
        logic [NB_W-1:0]  nbytes;
        logic             misaligned;
        logic             crosses;
    } decode_t;

    function automatic logic [NB_W-1:0] size_bytes(input size_e s);
        return NB_W'(1) << s;
    endfunction
endpackage

// File: rtl/mla_decode.sv
`timescale 1ns/1ps
module mla_decode
    import mla_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  size_e             size,
    output decode_t           dec
);
    logic [OFF_W-1:0] off;
    logic [NB_W-1:0]  nb;
    logic [NB_W-1:0]  end_pos;

    assign off     = addr[OFF_W-1:0];
    assign nb      = size_bytes(size);
    assign end_pos = NB_W'(off) + nb;

    always_comb begin
        dec.offset  = off;
        dec.nbytes  = nb;
        dec.crosses = end_pos > NB_W'(WORD_BYTES);
        unique case (size)
            SZ_BYTE: dec.misaligned = 1'b0;
            SZ_HALF: dec.misaligned = off[0];
            SZ_WORD: dec.misaligned = |off[1:0];
            default: dec.misaligned = |off;
        endcase
    end
endmodule

// File: rtl/mla_extract.sv
`timescale 1ns/1ps
module mla_extract
    import mla_pkg::*;
(
    input  logic [DATA_W-1:0] lo_word,
    input  logic [DATA_W-1:0] hi_word,
    input  logic [OFF_W-1:0]  offset,
    input  logic [NB_W-1:0]   nbytes,
    output logic [DATA_W-1:0] result
);
    logic [2*DATA_W-1:0] pair;
    logic [2*DATA_W-1:0] shifted;

    assign pair    = {hi_word, lo_word};
    assign shifted = pair >> {offset, 3'b000};

    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
        assign result[8*b +: 8] = (NB_W'(b) < nbytes) ? shifted[8*b +: 8] : 8'h00;
    end
endmodule

// File: rtl/mla_ctrl.sv
`timescale 1ns/1ps
module mla_ctrl
    import mla_pkg::*;
#(
    parameter int WADDR_W = 29
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               split_en,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [WADDR_W-1:0] req_waddr,
    input  decode_t            req_dec,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [WADDR_W-1:0] mem_waddr,
    input  logic               mem_rdata_valid,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0]  lo_word,
    output logic [DATA_W-1:0]  hi_word,
    output logic [OFF_W-1:0]   cur_offset,
    output logic [NB_W-1:0]    cur_nbytes,
    output logic               rsp_valid,
    output logic               rsp_fault
);
    state_e state;
    logic   sent;
    logic   cur_cross;
    logic   cur_fault;
    logic   accept;
    logic   handshake;
    logic   data_in;

    assign accept    = req_valid && req_ready;
    assign handshake = mem_req_valid && mem_req_ready;
    assign data_in   = sent && mem_rdata_valid;

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_READ_FIRST || state == ST_READ_SECOND) && !sent;
    assign rsp_valid     = (state == ST_RESPOND) && !cur_fault;
    assign rsp_fault     = (state == ST_RESPOND) && cur_fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            sent       <= 1'b0;
            cur_cross  <= 1'b0;
            cur_fault  <= 1'b0;
            cur_offset <= '0;
            cur_nbytes <= '0;
            mem_waddr  <= '0;
            lo_word    <= '0;
            hi_word    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cur_offset <= req_dec.offset;
                        cur_nbytes <= req_dec.nbytes;
                        cur_cross  <= req_dec.crosses;
                        mem_waddr  <= req_waddr;
                        sent       <= 1'b0;
                        if (req_dec.misaligned && !split_en) begin
                            cur_fault <= 1'b1;
                            state     <= ST_RESPOND;
                        end else begin
                            cur_fault <= 1'b0;
                            state     <= ST_READ_FIRST;
                        end
                    end
                end
                ST_READ_FIRST: begin
                    if (handshake) sent <= 1'b1;
                    if (data_in) begin
                        lo_word <= mem_rdata;
                        sent    <= 1'b0;
                        if (cur_cross) begin
                            mem_waddr <= mem_waddr + 1'b1;
                            state     <= ST_READ_SECOND;
                        end else begin
                            state <= ST_RESPOND;
                        end
                    end
                end
                ST_READ_SECOND: begin
                    if (handshake) sent <= 1'b1;
                    if (data_in) begin
                        hi_word <= mem_rdata;
                        sent    <= 1'b0;
                        state   <= ST_RESPOND;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // R9: an unaccepted memory request holds its address
    p_req_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_waddr)))
        else $error("p_req_stable_r9");

    // R11: response strobe lasts one cycle
    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid)
        else $error("p_rsp_pulse_r11");

    // R6: fault strobe lasts one cycle and carries no data strobe
    p_fault_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |=> (!rsp_fault && !rsp_valid))
        else $error("p_fault_pulse_r6");

    // R8: acceptance closes the request port
    p_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready)
        else $error("p_accept_busy_r8");
endmodule

// File: rtl/mla_adapter.sv
`timescale 1ns/1ps
module mla_adapter
    import mla_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int WADDR_W = ADDR_W - OFF_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                split_en,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                rsp_fault,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [WADDR_W-1:0]  mem_addr,
    input  logic                mem_rdata_valid,
    input  logic [DATA_W-1:0]   mem_rdata
);
    decode_t             dec;
    logic [DATA_W-1:0]   lo_word;
    logic [DATA_W-1:0]   hi_word;
    logic [OFF_W-1:0]    cur_offset;
    logic [NB_W-1:0]     cur_nbytes;

    mla_decode #(.ADDR_W(ADDR_W)) decode_i (
        .addr (req_addr),
        .size (size_e'(req_size)),
        .dec  (dec)
    );

    mla_ctrl #(.WADDR_W(WADDR_W)) ctrl_i (
        .clk             (clk),
        .rst             (rst),
        .split_en        (split_en),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_waddr       (req_addr[ADDR_W-1:OFF_W]),
        .req_dec         (dec),
        .mem_req_valid   (mem_req_valid),
        .mem_req_ready   (mem_req_ready),
        .mem_waddr       (mem_addr),
        .mem_rdata_valid (mem_rdata_valid),
        .mem_rdata       (mem_rdata),
        .lo_word         (lo_word),
        .hi_word         (hi_word),
        .cur_offset      (cur_offset),
        .cur_nbytes      (cur_nbytes),
        .rsp_valid       (rsp_valid),
        .rsp_fault       (rsp_fault)
    );

    mla_extract extract_i (
        .lo_word (lo_word),
        .hi_word (hi_word),
        .offset  (cur_offset),
        .nbytes  (cur_nbytes),
        .result  (rsp_data)
    );

    // R3: only a misaligned request can spill into a second word
    p_cross_needs_misalign_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dec.crosses) |-> dec.misaligned)
        else $error("p_cross_needs_misalign_r3");

    // R6: no memory traffic while a fault is reported
    p_fault_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (!mem_req_valid && !mem_rdata_valid))
        else $error("p_fault_quiet_r6");
endmodule

// File: tb/mla_adapter_tb_top.sv
`timescale 1ns/1ps
module mla_adapter_tb_top;
    localparam int AW  = 16;
    localparam int WAW = AW - 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           split_en = 1'b1;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [AW-1:0]  req_addr = '0;
    logic [1:0]     req_size = '0;
    logic           rsp_valid;
    logic [63:0]    rsp_data;
    logic           rsp_fault;
    logic           mem_req_valid;
    logic           mem_req_ready;
    logic [WAW-1:0] mem_addr;
    logic           mem_rdata_valid = 1'b0;
    logic [63:0]    mem_rdata = '0;

    int total = 0;
    int fails = 0;
    int lat   = 1;
    bit stall = 1'b0;
    bit done  = 1'b0;
    int cyc   = 0;

    int             nreads = 0;
    logic [WAW-1:0] a_prev = '0;
    logic [WAW-1:0] a_last = '0;
    bit             pend = 1'b0;
    int             wait_c = 0;
    logic [WAW-1:0] paddr = '0;

    always #2.5 clk = ~clk;

    mla_adapter #(.ADDR_W(AW)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .split_en        (split_en),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_addr        (req_addr),
        .req_size        (req_size),
        .rsp_valid       (rsp_valid),
        .rsp_data        (rsp_data),
        .rsp_fault       (rsp_fault),
        .mem_req_valid   (mem_req_valid),
        .mem_req_ready   (mem_req_ready),
        .mem_addr        (mem_addr),
        .mem_rdata_valid (mem_rdata_valid),
        .mem_rdata       (mem_rdata)
    );

    function automatic logic [7:0] mem_byte(input int a);
        int v;
        v = (a * 37 + 11) ^ (a >> 5);
        return v[7:0];
    endfunction

    function automatic logic [63:0] word_at(input int w);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = mem_byte(w * 8 + i);
        return r;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;
    assign mem_req_ready = stall ? ((cyc % 3) == 2) : 1'b1;

    always @(posedge clk) begin
        mem_rdata_valid <= 1'b0;
        if (rst) begin
            pend <= 1'b0;
        end else begin
            if (pend) begin
                if (wait_c == 0) begin
                    mem_rdata_valid <= 1'b1;
                    mem_rdata       <= word_at(int'(paddr));
                    pend            <= 1'b0;
                end else begin
                    wait_c <= wait_c - 1;
                end
            end
            if (mem_req_valid && mem_req_ready) begin
                pend   <= 1'b1;
                wait_c <= lat - 1;
                paddr  <= mem_addr;
                a_prev <= a_last;
                a_last <= mem_addr;
                nreads <= nreads + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input int addr, input int sz, input bit split);
        int          nb, off, start, n, exp_reads;
        bit          exp_fault, busy_ok, got_v, got_f;
        logic [63:0] exp_data, got_data;
        nb  = 1 << sz;
        off = addr % 8;
        exp_fault = !split && ((addr % nb) != 0);
        exp_reads = exp_fault ? 0 : ((off + nb > 8) ? 2 : 1);
        exp_data  = '0;
        for (int i = 0; i < nb; i++) exp_data[8*i +: 8] = mem_byte(addr + i);

        @(negedge clk);
        split_en  = split;
        req_valid = 1'b1;
        req_addr  = AW'(addr);
        req_size  = 2'(sz);
        start     = nreads;
        chk(req_ready == 1'b1, "R8 idle ready", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        busy_ok = 1'b1;
        while (!rsp_valid && !rsp_fault && n < 200) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            n++;
        end
        chk(n < 200, "R9 completion", 64'(n), 64'd0);
        if (req_ready) busy_ok = 1'b0;
        chk(busy_ok, "R8 ready low in flight", 64'(busy_ok), 64'd1);
        got_v    = rsp_valid;
        got_f    = rsp_fault;
        got_data = rsp_data;

        chk(got_f == exp_fault, "R6 fault flag", 64'(got_f), 64'(exp_fault));
        chk(got_v == !exp_fault, "R7 valid flag", 64'(got_v), 64'(!exp_fault));
        if (exp_reads == 2)
            chk(nreads - start == 2, "R3 two reads", 64'(nreads - start), 64'd2);
        else if (exp_reads == 1)
            chk(nreads - start == 1, "R2 one read", 64'(nreads - start), 64'd1);
        else
            chk(nreads - start == 0, "R6 no read", 64'(nreads - start), 64'd0);

        if (exp_reads == 1 && nreads - start == 1)
            chk(a_last == WAW'(addr >> 3), "R1 word index", 64'(a_last), 64'(addr >> 3));
        if (exp_reads == 2 && nreads - start == 2) begin
            chk(a_prev == WAW'(addr >> 3), "R1 first word", 64'(a_prev), 64'(addr >> 3));
            chk(a_last == WAW'((addr >> 3) + 1), "R3 second word", 64'(a_last), 64'((addr >> 3) + 1));
        end
        if (!exp_fault) begin
            if (exp_reads == 2)
                chk(got_data == exp_data, "R4 merged data", got_data, exp_data);
            else
                chk(got_data == exp_data, "R2 byte select", got_data, exp_data);
            if (nb < 8)
                chk((got_data >> (8 * nb)) == 64'd0, "R5 zero extension",
                    got_data >> (8 * nb), 64'd0);
        end

        @(negedge clk);
        chk(!rsp_valid, "R11 valid pulse", 64'(rsp_valid), 64'd0);
        chk(!rsp_fault, "R6 fault pulse", 64'(rsp_fault), 64'd0);
        chk(req_ready, "R8 ready restored", 64'(req_ready), 64'd1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(req_ready == 1'b1, "R10 reset ready", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R10 reset valid", 64'(rsp_valid), 64'd0);
        chk(rsp_fault == 1'b0, "R10 reset fault", 64'(rsp_fault), 64'd0);
        chk(mem_req_valid == 1'b0, "R10 reset mem req", 64'(mem_req_valid), 64'd0);

        lat = 1;
        stall = 1'b0;
        for (int mode = 1; mode >= 0; mode--)
            for (int a = 0; a < 24; a++)
                for (int s = 0; s < 4; s++)
                    do_load(a, s, bit'(mode));

        lat = 3;
        stall = 1'b1;
        for (int mode = 1; mode >= 0; mode--)
            for (int a = 16'h1230; a < 16'h1240; a++)
                for (int s = 0; s < 4; s++)
                    do_load(a, s, bit'(mode));

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule